// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block is a write-only serial slave. A host drives a data line, a serial clock and an active-low frame strobe. The block turns each 16-bit frame into an update of one of two 15-bit configuration words. It samples all three lines through synchronisers into a faster system clock and detects their edges there. While the strobe is low, the block shifts one data bit in on every falling serial-clock edge. The least significant bit arrives first.

When the strobe rises, the last bit received decides the destination. If that bit is 0, the other fifteen bits go into the settings word. If it is 1, they go into the drive word. A frame commits only if exactly sixteen bits were shifted. Each word is presented raw, and the block also splits it into named per-bridge fields.

After reset releases, the block ignores the serial lines for a programmable number of system-clock cycles.

Top module: `cfg_serial_regs`

## Requirements
- R1: While reset is low and after it releases, both stored words read all zeros and `wr_pulse_o` is low.
- R2: Frame bit i is the i-th bit on the data line, counted from 0. Bit i is captured on the i-th falling serial-clock edge while the strobe is low. After a commit, stored word bit i (i = 0..14) equals frame bit i.
- R3: Falling serial-clock edges that occur while the strobe is high are not captured. This includes an edge seen in the same sampled cycle as the strobe rise.
- R4: Frame bit 15 selects the destination: 0 writes the settings word and 1 writes the drive word. The word that is not selected keeps its value.
- R5: If the strobe rises after fewer than 16 or more than 16 captured edges, the frame is discarded and neither word changes.
- R6: The settings word maps to the following fields:
  - Bridge-1 off time is {bit8, bit9, bit10}, with bit 8 as the MSB, on `off_time_o[2:0]`.
  - Bridge-1 blank time is {bit11, bit12} on `blank_o[1:0]`.
  - Bridge-2 off time is {bit3, bit4, bit5} on `off_time_o[5:3]`.
  - Bridge-2 blank time is {bit6, bit7} on `blank_o[3:2]`.
  - Mask select is bit 13.
  - Switcher off is bit 14.
- R7: The drive word maps to the following fields, where index 0 of each 2-bit output is bridge 1 and index 1 is bridge 2:
  - Bridge 2 uses bit 9 for PWM mode, bit 10 for phase and bit 11 for enable.
  - Bridge 1 uses bit 12 for PWM mode, bit 13 for phase and bit 14 for enable.
- R8: During the first HOLDOFF_CYCLES system-clock cycles after reset releases, no serial edge is accepted and no word changes.
- R9: Each commit produces a `wr_pulse_o` high for exactly one cycle, with `wr_sel_o` equal to frame bit 15. No pulse is produced without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; idle high, data captured on falling edge |
| ser_dat_i | input | 1 | Serial data, LSB first |
| ser_stb_i | input | 1 | Frame strobe; low during a frame, rising edge commits |
| set_word_o | output | 15 | Stored settings word |
| drv_word_o | output | 15 | Stored drive word |
| off_time_o | output | 6 | Off time per bridge ([2:0] bridge 1, [5:3] bridge 2) |
| blank_o | output | 4 | Blank time per bridge ([1:0] bridge 1, [3:2] bridge 2) |
| mask_sel_o | output | 1 | Mask select setting |
| sw_off_o | output | 1 | Switcher off setting |
| pwm_mode_o | output | 2 | PWM mode per bridge |
| phase_o | output | 2 | Phase per bridge |
| enable_o | output | 2 | Enable per bridge |
| wr_pulse_o | output | 1 | One-cycle pulse on each commit |
| wr_sel_o | output | 1 | Word written by the last commit (0 settings, 1 drive) |

## Verification
Two things can land in the same synchronised cycle: the strobe rise that commits a frame, and a falling serial-clock edge. The bench provokes this by driving a seventeenth falling clock edge at the exact instant the strobe goes high. Both lines pass through equal-length synchronisers, so the block sees both edges together.

The outcome is judged at the ports. The frame must commit as a 16-bit frame, with the expected word contents and exactly one write pulse. It must not be dropped as a 17-bit frame. A second overlap is also tested: a complete frame sent entirely inside the post-reset hold-off. Its strobe rise must leave both words at zero.

// File: rtl/cfg_serial_pkg.sv
// Package: shared widths and field positions for the serial configuration loader.
// Assumes a 16-bit frame whose top bit is the word select.
package cfg_serial_pkg;

    localparam int FRAME_W = 16;
    localparam int WORD_W  = FRAME_W - 1;
    localparam int N_BRIDGE = 2;
    localparam int OFF_W    = 3;
    localparam int BLANK_W  = 2;

    // Word-select encoding carried by the last frame bit
    typedef enum logic {
        SEL_SETTINGS = 1'b0,
        SEL_DRIVE    = 1'b1
    } word_sel_e;

    // Settings word: position of the off-time MSB for a bridge (0 = bridge 1)
    function automatic int off_msb_pos(input int bridge);
        return (bridge == 0) ? 8 : 3;
    endfunction

    // Settings word: position of the blank-time MSB for a bridge
    function automatic int blank_msb_pos(input int bridge);
        return (bridge == 0) ? 11 : 6;
    endfunction

    // Drive word: position of the PWM-mode bit; phase and enable follow it
    function automatic int drive_base_pos(input int bridge);
        return (bridge == 0) ? 12 : 9;
    endfunction

    localparam int MASK_POS  = 13;
    localparam int SWOFF_POS = 14;

endpackage

// File: rtl/cser_sync.sv
// Module: cser_sync
// Multi-stage synchroniser for one asynchronous serial line.
// Assumes STAGES >= 2; the reset value matches the line's idle level so that
// no false edge appears when reset releases.
module cser_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe <= {STAGES{RST_VAL}};
        else
            pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/cser_holdoff.sv
// Module: cser_holdoff
// Counts system clocks after reset release; raises armed once the count
// reaches HOLD_CYCLES and keeps it high until the next reset.
// Assumes HOLD_CYCLES >= 1.
module cser_holdoff #(
    parameter int HOLD_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Count up to the hold-off limit and then stop
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != CNT_W'(HOLD_CYCLES))
            cnt <= cnt + 1'b1;
    end

    assign armed = (cnt == CNT_W'(HOLD_CYCLES));

    // R8: once armed, stays armed until reset
    p_armed_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

endmodule

// File: rtl/cser_shifter.sv
// Module: cser_shifter
// Detects edges on the synchronised serial lines, shifts data LSB first on
// falling serial-clock edges while the strobe is low, counts the captured bits
// and raises commit on a strobe rise that ends an exact-length frame.
// Assumes inputs are already synchronised to clk.
module cser_shifter
    import cfg_serial_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               armed,
    input  logic               sclk,
    input  logic               sdat,
    input  logic               sstb,
    output logic               commit,
    output logic [FRAME_W-1:0] frame
);

    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam int CNT_MAX = FRAME_W + 1;

    logic             sclk_q;
    logic             sstb_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             clk_fall;
    logic             stb_rise;
    logic             stb_fall;
    logic             shift_en;

    // Remember the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            sstb_q <= 1'b1;
        end else begin
            sclk_q <= sclk;
            sstb_q <= sstb;
        end
    end

    assign clk_fall = sclk_q & ~sclk;
    assign stb_rise = ~sstb_q & sstb;
    assign stb_fall = sstb_q & ~sstb;
    assign shift_en = armed & clk_fall & ~sstb;

    // Shift data in LSB first: newest bit enters at the top
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame <= '0;
        else if (shift_en)
            frame <= {sdat, frame[FRAME_W-1:1]};
    end

    // Count captured bits per frame, saturating one past the frame length
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (stb_rise || stb_fall)
            bit_cnt <= '0;
        else if (shift_en && bit_cnt != CNT_W'(CNT_MAX))
            bit_cnt <= bit_cnt + 1'b1;
    end

    assign commit = armed & stb_rise & (bit_cnt == CNT_W'(FRAME_W));

    // R3: a high strobe freezes the shift register
    p_frozen_when_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sstb |=> $stable(frame));

    // R8: nothing is shifted before the hold-off expires
    p_idle_until_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(frame));

endmodule

// File: rtl/cser_store.sv
// Module: cser_store
// Holds the two configuration words, writes the one picked by the top frame
// bit on commit, emits the write pulse and splits both words into fields.
// Assumes commit lasts at most one cycle per frame.
module cser_store
    import cfg_serial_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit,
    input  logic [FRAME_W-1:0]              frame,
    output logic [WORD_W-1:0]               set_word,
    output logic [WORD_W-1:0]               drv_word,
    output logic                            wr_pulse,
    output logic                            wr_sel,
    output logic [N_BRIDGE*OFF_W-1:0]       off_time,
    output logic [N_BRIDGE*BLANK_W-1:0]     blank,
    output logic                            mask_sel,
    output logic                            sw_off,
    output logic [N_BRIDGE-1:0]             pwm_mode,
    output logic [N_BRIDGE-1:0]             phase,
    output logic [N_BRIDGE-1:0]             enable
);

    word_sel_e dest;
    assign dest = word_sel_e'(frame[FRAME_W-1]);

    // Write the addressed word on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_word <= '0;
            drv_word <= '0;
        end else if (commit) begin
            if (dest == SEL_DRIVE)
                drv_word <= frame[WORD_W-1:0];
            else
                set_word <= frame[WORD_W-1:0];
        end
    end

    // Produce the one-cycle write pulse and record the destination
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pulse <= 1'b0;
            wr_sel   <= 1'b0;
        end else begin
            wr_pulse <= commit;
            if (commit)
                wr_sel <= frame[FRAME_W-1];
        end
    end

    // Per-bridge field split of both words
    for (genvar b = 0; b < N_BRIDGE; b++) begin : g_bridge
        localparam int OM = off_msb_pos(b);
        localparam int BM = blank_msb_pos(b);
        localparam int DB = drive_base_pos(b);
        assign off_time[b*OFF_W +: OFF_W]     = {set_word[OM], set_word[OM+1], set_word[OM+2]};
        assign blank[b*BLANK_W +: BLANK_W]    = {set_word[BM], set_word[BM+1]};
        assign pwm_mode[b]                    = drv_word[DB];
        assign phase[b]                       = drv_word[DB+1];
        assign enable[b]                      = drv_word[DB+2];
    end

    assign mask_sel = set_word[MASK_POS];
    assign sw_off   = set_word[SWOFF_POS];

    // R9: the write pulse never lasts two cycles
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R4: writing the drive word leaves the settings word alone
    p_settings_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wr_pulse && wr_sel) |-> $stable(set_word));

    // R4: writing the settings word leaves the drive word alone
    p_drive_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wr_pulse && !wr_sel) |-> $stable(drv_word));

    // R5: without a write pulse neither word moves
    p_no_silent_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wr_pulse) |-> ($stable(set_word) && $stable(drv_word)));

endmodule

// File: rtl/cfg_serial_regs.sv
// Module: cfg_serial_regs (top)
// Serial configuration loader: synchronises the three serial lines,
// blocks them for a hold-off after reset, assembles 16-bit frames and stores
// them into the settings or drive word. Assumes clk is several times faster
// than the serial clock so every level lasts at least SYNC_STAGES+1 cycles.
module cfg_serial_regs #(
    parameter int SYNC_STAGES  = 2,
    parameter int HOLDOFF_CYCLES = 2500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk_i,
    input  logic        ser_dat_i,
    input  logic        ser_stb_i,
    output logic [14:0] set_word_o,
    output logic [14:0] drv_word_o,
    output logic [5:0]  off_time_o,
    output logic [3:0]  blank_o,
    output logic        mask_sel_o,
    output logic        sw_off_o,
    output logic [1:0]  pwm_mode_o,
    output logic [1:0]  phase_o,
    output logic [1:0]  enable_o,
    output logic        wr_pulse_o,
    output logic        wr_sel_o
);
    import cfg_serial_pkg::*;

    logic                sclk_s;
    logic                sdat_s;
    logic                sstb_s;
    logic                armed;
    logic                commit;
    logic [FRAME_W-1:0]  frame;

    cser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(ser_clk_i), .q(sclk_s));
    cser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(ser_dat_i), .q(sdat_s));
    cser_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stb (
        .clk(clk), .rst_n(rst_n), .d(ser_stb_i), .q(sstb_s));

    cser_holdoff #(.HOLD_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
        .clk(clk), .rst_n(rst_n), .armed(armed));

    cser_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .sclk(sclk_s), .sdat(sdat_s), .sstb(sstb_s),
        .commit(commit), .frame(frame));

    cser_store u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .frame(frame),
        .set_word(set_word_o), .drv_word(drv_word_o),
        .wr_pulse(wr_pulse_o), .wr_sel(wr_sel_o),
        .off_time(off_time_o), .blank(blank_o),
        .mask_sel(mask_sel_o), .sw_off(sw_off_o),
        .pwm_mode(pwm_mode_o), .phase(phase_o), .enable(enable_o));

    // R8: no write pulse while still held off
    p_no_write_before_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !wr_pulse_o);

    // R1: reset state of the pulse is low on the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !wr_pulse_o);

endmodule

// File: tb/tb_cfg_serial_regs.sv
// Bench for cfg_serial_regs: vector table walk, then directed corner cases.
module tb_cfg_serial_regs;

    localparam int HOLD = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk_i = 1'b1;
    logic        ser_dat_i = 1'b0;
    logic        ser_stb_i = 1'b1;
    logic [14:0] set_word_o, drv_word_o;
    logic [5:0]  off_time_o;
    logic [3:0]  blank_o;
    logic        mask_sel_o, sw_off_o;
    logic [1:0]  pwm_mode_o, phase_o, enable_o;
    logic        wr_pulse_o, wr_sel_o;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    int n_wide = 0;
    logic last_sel = 1'b0;
    logic prev_pulse = 1'b0;
    logic done = 1'b0;

    logic [14:0] m_set = '0;
    logic [14:0] m_drv = '0;
    int exp_pulse = 0;
    logic exp_sel = 1'b0;

    always #10 clk = ~clk;

    cfg_serial_regs #(.SYNC_STAGES(2), .HOLDOFF_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i), .ser_stb_i(ser_stb_i),
        .set_word_o(set_word_o), .drv_word_o(drv_word_o),
        .off_time_o(off_time_o), .blank_o(blank_o),
        .mask_sel_o(mask_sel_o), .sw_off_o(sw_off_o),
        .pwm_mode_o(pwm_mode_o), .phase_o(phase_o), .enable_o(enable_o),
        .wr_pulse_o(wr_pulse_o), .wr_sel_o(wr_sel_o));

    // Pulse monitor sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_pulse = 1'b0;
        end else begin
            if (wr_pulse_o) begin
                n_pulse++;
                last_sel = wr_sel_o;
                if (prev_pulse) n_wide++;
            end
            prev_pulse = wr_pulse_o;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Full comparison of all outputs against the bench model
    task automatic check_all(input string tag);
        chk({tag, " R2/R4 settings word"}, 32'(set_word_o), 32'(m_set));
        chk({tag, " R2/R4 drive word"},   32'(drv_word_o), 32'(m_drv));
        chk({tag, " R6 off times"}, 32'(off_time_o),
            32'({m_set[3], m_set[4], m_set[5], m_set[8], m_set[9], m_set[10]}));
        chk({tag, " R6 blank times"}, 32'(blank_o),
            32'({m_set[6], m_set[7], m_set[11], m_set[12]}));
        chk({tag, " R6 mask/swoff"}, 32'({mask_sel_o, sw_off_o}), 32'({m_set[13], m_set[14]}));
        chk({tag, " R7 pwm mode"}, 32'(pwm_mode_o), 32'({m_drv[9],  m_drv[12]}));
        chk({tag, " R7 phase"},    32'(phase_o),    32'({m_drv[10], m_drv[13]}));
        chk({tag, " R7 enable"},   32'(enable_o),   32'({m_drv[11], m_drv[14]}));
        chk({tag, " R9 pulse count"}, 32'(n_pulse), 32'(exp_pulse));
        chk({tag, " R9 pulse width"}, 32'(n_wide), 32'd0);
        if (exp_pulse > 0) chk({tag, " R9 select"}, 32'(last_sel), 32'(exp_sel));
    endtask

    // Send n bits LSB first; optionally put one extra falling edge on the strobe rise
    task automatic send_frame(input logic [31:0] bits, input int n, input bit collide);
        ser_stb_i = 1'b0;
        wait_clk(6);
        for (int i = 0; i < n; i++) begin
            ser_dat_i = bits[i];
            wait_clk(4);
            ser_clk_i = 1'b0;
            wait_clk(4);
            ser_clk_i = 1'b1;
        end
        wait_clk(4);
        if (collide) ser_clk_i = 1'b0;
        ser_stb_i = 1'b1;
        wait_clk(4);
        ser_clk_i = 1'b1;
        wait_clk(6);
    endtask

    // Bench model of a frame's effect
    task automatic model(input logic [31:0] bits, input int n);
        if (n == 16) begin
            if (bits[15]) m_drv = bits[14:0];
            else          m_set = bits[14:0];
            exp_pulse++;
            exp_sel = bits[15];
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(3);
        chk("R1 words zero in reset", 32'({set_word_o, drv_word_o}), 32'd0);
        chk("R1 pulse low in reset", 32'(wr_pulse_o), 32'd0);
        rst_n = 1'b1;
        m_set = '0;
        m_drv = '0;
    endtask

    // {bit count, frame}
    localparam logic [20:0] VEC [10] = '{
        {5'd16, 16'h7FFF},
        {5'd16, 16'hC000},
        {5'd16, 16'h2A38},
        {5'd15, 16'hFFFF},
        {5'd16, 16'h8E00},
        {5'd17, 16'h1234},
        {5'd16, 16'h0008},
        {5'd16, 16'hA5A5},
        {5'd1,  16'h0001},
        {5'd16, 16'h5B60}
    };

    initial begin
        do_reset();
        // R8: a complete frame inside the hold-off window is ignored
        send_frame(32'h0000_7FFF, 16, 1'b0);
        chk("R8 holdoff settings", 32'(set_word_o), 32'd0);
        chk("R8 holdoff pulse", 32'(n_pulse), 32'd0);
        wait_clk(HOLD);
        check_all("R1 post-holdoff");

        for (int v = 0; v < 10; v++) begin
            send_frame(32'(VEC[v][15:0]), int'(VEC[v][20:16]), 1'b0);
            model(32'(VEC[v][15:0]), int'(VEC[v][20:16]));
            check_all($sformatf("vec%0d R5", v));
        end

        // R3: clock edges with strobe high are not captured
        ser_dat_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_clk(4); ser_clk_i = 1'b0; wait_clk(4); ser_clk_i = 1'b1;
        end
        send_frame(32'h0000_0C01, 16, 1'b0);
        model(32'h0000_0C01, 16);
        check_all("R3 strobe-high edges");

        // R3: falling edge coinciding with strobe rise is not the 17th bit
        send_frame(32'h0000_9600, 16, 1'b1);
        model(32'h0000_9600, 16);
        check_all("R3 collision");

        // R1: reset mid-operation restores defaults
        do_reset();
        wait_clk(2);
        chk("R1 words zero after release", 32'({set_word_o, drv_word_o}), 32'd0);
        wait_clk(HOLD);
        send_frame(32'h0000_8800, 16, 1'b0);
        model(32'h0000_8800, 16);
        check_all("R4 after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule